// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame addressed to a group (multicast) destination should be kept. The destination address arrives one byte per cycle from the receive path. While the bytes arrive, the block runs the Ethernet CRC-32 over them. When the final byte arrives, it turns eight bits of the result into a bin number between 0 and 255. One cycle later it reports whether that bin is enabled in a 256-entry membership table.

The membership table is spread over eight 32-bit registers. Host software can reach it in two ways. It can overwrite a whole register and read any register back. It can also hand the block a full destination address and ask it to set or clear the single bin that address hashes to, leaving every other bin alone. All bins start cleared, so after reset no frame passes until software enables some bins.

Top module: `mhf_filter`

## Requirements
- R1: After reset all eight table registers read as zero, and `acceptValid` and `accept` are low.
- R2: The bin of an address is computed with the reflected Ethernet CRC-32 (polynomial 0xEDB88320). The CRC starts at all ones, is fed byte 0 first with each byte taken LSB first, and gets no final inversion. The bin is the top 8 bits of the bit-reversed CRC, that is bin[7-i] = crc[i] for i = 0..7.
- R3: Bin b lives in register b[7:5] at bit position 31 - b[4:0], so bin 0 is bit 31 of register 0 and bin 255 is bit 0 of register 7.
- R4: `acceptValid` pulses high for exactly the one cycle after the cycle in which a byte is presented with `rxValid` and `rxLast` both high. It is low in every other cycle.
- R5: `accept` can be high only while `acceptValid` is high. It is high only if the frame's bin is set and the group bit (bit 0 of address byte 0) is 1, so a set bin never passes an individual address.
- R6: A host write with `hostWrEn` replaces the whole register `hostWrIdx`. `hostRdData` always shows register `hostRdIdx` without delay.
- R7: `cmdSet` sets the one bin that `cmdMac` hashes to and changes no other bit. `cmdMac` holds byte 0 in bits [7:0] and byte 5 in bits [47:40].
- R8: `cmdClr` clears the one bin that `cmdMac` hashes to and changes no other bit.
- R9: When several host actions meet in one cycle, the register write is applied first and the bin command on top of it. If `cmdSet` and `cmdClr` are both high, the set wins.
- R10: A bin command issued in the same cycle as a frame's last byte does not affect that frame's decision. It takes effect from the next frame on.
- R11: Cycles with `rxValid` low inside an address leave the running CRC untouched. After a last byte, the next valid byte starts a new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxValid | input | 1 | Address byte present on `rxByte` |
| rxLast | input | 1 | Current byte is the sixth (final) address byte |
| rxByte | input | 8 | Destination address byte, byte 0 first |
| acceptValid | output | 1 | Filter decision available |
| accept | output | 1 | Frame passes the group hash filter |
| hostWrEn | input | 1 | Write whole table register |
| hostWrIdx | input | 3 | Register written |
| hostWrData | input | 32 | Write data |
| hostRdIdx | input | 3 | Register read |
| hostRdData | output | 32 | Contents of register `hostRdIdx` |
| cmdSet | input | 1 | Set the bin of `cmdMac` |
| cmdClr | input | 1 | Clear the bin of `cmdMac` |
| cmdMac | input | 48 | Address whose bin the command targets |

## Verification
The assertions assume the receive source marks exactly one byte of each address with `rxLast`. They also assume the first valid byte after reset or after a last byte is address byte 0. The group-bit check depends on that framing. The write/read property assumes no bin command lands in the same cycle as the write it observes. The bench only ever sends complete six-byte addresses. It keeps writes and commands in separate cycles except in the one scenario that exercises their combined ordering. It holds the receive strobes low between frames, apart from deliberate gap cycles.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef struct packed {
    logic step;    // a byte is consumed
    logic first;   // the byte opens a new address
    logic lookup;  // the byte closes the address
  } mhfStrobe_t;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] crcIn,
                                               input logic [7:0] dataIn);
    logic [CRC_W-1:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ dataIn[i]) c = (c >> 1) ^ CRC_POLY_REFL;
      else                  c = c >> 1;
    end
    return c;
  endfunction
endpackage

// File: rtl/mhf_ctrl.sv
module mhf_ctrl
  import mhf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxValid,
  input  logic       rxLast,
  output mhfStrobe_t strobe
);
  logic expectFirst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        expectFirst <= 1'b1;
    else if (rxValid) expectFirst <= rxLast;
  end

  always_comb begin
    strobe.step   = rxValid;
    strobe.first  = rxValid & expectFirst;
    strobe.lookup = rxValid & rxLast;
  end
endmodule

// File: rtl/mhf_datapath.sv
module mhf_datapath
  import mhf_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 8,
  parameter int unsigned REG_W      = 32,
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  mhfStrobe_t                    strobe,
  input  logic [7:0]                    rxByte,
  input  logic                          hostWrEn,
  input  logic [$clog2(NUM_REGS)-1:0]   hostWrIdx,
  input  logic [REG_W-1:0]              hostWrData,
  input  logic [$clog2(NUM_REGS)-1:0]   hostRdIdx,
  output logic [REG_W-1:0]              hostRdData,
  input  logic                          cmdSet,
  input  logic                          cmdClr,
  input  logic [8*ADDR_BYTES-1:0]       cmdMac,
  output logic                          acceptValid,
  output logic                          accept
);
  localparam int unsigned SEL_W = $clog2(NUM_REGS);
  localparam int unsigned POS_W = $clog2(REG_W);
  localparam int unsigned IDX_W = SEL_W + POS_W;

  function automatic logic [IDX_W-1:0] binOf(input logic [CRC_W-1:0] c);
    logic [IDX_W-1:0] b;
    for (int i = 0; i < IDX_W; i++) b[IDX_W-1-i] = c[i];
    return b;
  endfunction

  logic [REG_W-1:0] binTable [NUM_REGS];
  logic [CRC_W-1:0] crcReg, crcNext, cmdCrc;
  logic             grpReg, grpNow, lookHit;
  logic [IDX_W-1:0] lookIdx, cmdIdx;
  logic [POS_W-1:0] lookPos, cmdPos;
  logic [SEL_W-1:0] cmdSel;
  logic [REG_W-1:0] cmdMask;

  // running hash of the receive address
  always_comb begin
    crcNext = crcByte(strobe.first ? {CRC_W{1'b1}} : crcReg, rxByte);
    grpNow  = strobe.first ? rxByte[0] : grpReg;
    lookIdx = binOf(crcNext);
    lookPos = POS_W'(REG_W - 1) - lookIdx[POS_W-1:0];
    lookHit = binTable[lookIdx[IDX_W-1 -: SEL_W]][lookPos];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crcReg      <= '1;
      grpReg      <= 1'b0;
      acceptValid <= 1'b0;
      accept      <= 1'b0;
    end else begin
      if (strobe.step)  crcReg <= crcNext;
      if (strobe.first) grpReg <= rxByte[0];
      acceptValid <= strobe.lookup;
      accept      <= strobe.lookup & lookHit & grpNow;
    end
  end

  // hash of the command address
  always_comb begin
    cmdCrc = {CRC_W{1'b1}};
    for (int b = 0; b < ADDR_BYTES; b++) cmdCrc = crcByte(cmdCrc, cmdMac[8*b +: 8]);
    cmdIdx  = binOf(cmdCrc);
    cmdSel  = cmdIdx[IDX_W-1 -: SEL_W];
    cmdPos  = POS_W'(REG_W - 1) - cmdIdx[POS_W-1:0];
    cmdMask = {{(REG_W-1){1'b0}}, 1'b1} << cmdPos;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [REG_W-1:0] afterWr;
    logic             cmdHere;
    always_comb begin
      afterWr = (hostWrEn && hostWrIdx == SEL_W'(r)) ? hostWrData : binTable[r];
      cmdHere = (cmdSel == SEL_W'(r));
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 binTable[r] <= '0;
      else if (cmdHere && cmdSet) binTable[r] <= afterWr | cmdMask;
      else if (cmdHere && cmdClr) binTable[r] <= afterWr & ~cmdMask;
      else                       binTable[r] <= afterWr;
    end
  end

  assign hostRdData = binTable[hostRdIdx];
endmodule

// File: rtl/mhf_filter.sv
module mhf_filter
  import mhf_pkg::*;
#(
  parameter int unsigned NUM_REGS   = 8,
  parameter int unsigned REG_W      = 32,
  parameter int unsigned ADDR_BYTES = 6
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        rxValid,
  input  logic                        rxLast,
  input  logic [7:0]                  rxByte,
  output logic                        acceptValid,
  output logic                        accept,
  input  logic                        hostWrEn,
  input  logic [$clog2(NUM_REGS)-1:0] hostWrIdx,
  input  logic [REG_W-1:0]            hostWrData,
  input  logic [$clog2(NUM_REGS)-1:0] hostRdIdx,
  output logic [REG_W-1:0]            hostRdData,
  input  logic                        cmdSet,
  input  logic                        cmdClr,
  input  logic [8*ADDR_BYTES-1:0]     cmdMac
);
  mhfStrobe_t strobe;

  mhf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxLast(rxLast), .strobe(strobe)
  );

  mhf_datapath #(.NUM_REGS(NUM_REGS), .REG_W(REG_W), .ADDR_BYTES(ADDR_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .hostWrEn(hostWrEn), .hostWrIdx(hostWrIdx), .hostWrData(hostWrData),
    .hostRdIdx(hostRdIdx), .hostRdData(hostRdData),
    .cmdSet(cmdSet), .cmdClr(cmdClr), .cmdMac(cmdMac),
    .acceptValid(acceptValid), .accept(accept)
  );
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int unsigned SEL_W = 3,
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             rxLast,
  input logic             rxLsb,
  input logic             acceptValid,
  input logic             accept,
  input logic             hostWrEn,
  input logic [SEL_W-1:0] hostWrIdx,
  input logic [REG_W-1:0] hostWrData,
  input logic [SEL_W-1:0] hostRdIdx,
  input logic [REG_W-1:0] hostRdData,
  input logic             cmdSet
);
  logic everPopulated, openNext, lsbHeld, grpAtLast;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      everPopulated <= 1'b0;
      openNext      <= 1'b1;
      lsbHeld       <= 1'b0;
    end else begin
      if (cmdSet || (hostWrEn && hostWrData != '0)) everPopulated <= 1'b1;
      if (rxValid) openNext <= rxLast;
      if (rxValid && openNext) lsbHeld <= rxLsb;
    end
  end

  assign grpAtLast = openNext ? rxLsb : lsbHeld;

  assert_empty_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> everPopulated);

  assert_decision_follows_last_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxLast) |=> acceptValid);

  assert_no_spurious_decision_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rxValid && rxLast) |=> !acceptValid);

  assert_accept_qualified_R5: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> acceptValid);

  assert_individual_rejected_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxLast && !grpAtLast) |=> !accept);

  assert_write_readback_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !cmdSet) |=> ((hostRdIdx == $past(hostWrIdx)) -> (hostRdData == $past(hostWrData))));
endmodule

bind mhf_filter mhf_checker #(.SEL_W($clog2(NUM_REGS)), .REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxLast(rxLast), .rxLsb(rxByte[0]),
  .acceptValid(acceptValid), .accept(accept), .hostWrEn(hostWrEn),
  .hostWrIdx(hostWrIdx), .hostWrData(hostWrData), .hostRdIdx(hostRdIdx),
  .hostRdData(hostRdData), .cmdSet(cmdSet)
);

// File: tb/test_mhf_filter.sv
module test_mhf_filter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rxValid = 1'b0, rxLast = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        acceptValid, accept;
  logic        hostWrEn = 1'b0;
  logic [2:0]  hostWrIdx = '0, hostRdIdx = '0;
  logic [31:0] hostWrData = '0, hostRdData;
  logic        cmdSet = 1'b0, cmdClr = 1'b0;
  logic [47:0] cmdMac = '0;

  int checks = 0, errors = 0;
  logic [31:0] mdl [8];

  always #2 clk = ~clk;

  mhf_filter i_mhf_filter (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxLast(rxLast), .rxByte(rxByte),
    .acceptValid(acceptValid), .accept(accept), .hostWrEn(hostWrEn),
    .hostWrIdx(hostWrIdx), .hostWrData(hostWrData), .hostRdIdx(hostRdIdx),
    .hostRdData(hostRdData), .cmdSet(cmdSet), .cmdClr(cmdClr), .cmdMac(cmdMac)
  );

  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  // R2: reference bin computed bit by bit over the 48 address bits
  function automatic logic [7:0] binRef(input logic [47:0] mac);
    logic [31:0] c, rev;
    c = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = c[0] ^ mac[i];
      c = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    for (int j = 0; j < 32; j++) rev[31-j] = c[j];
    return rev[31:24];
  endfunction

  // R3: mask of a bin inside its register
  function automatic logic [31:0] maskOf(input logic [7:0] b);
    return 32'h80000000 >> b[4:0];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input logic [2:0] idx, output logic [31:0] val);
    hostRdIdx = idx;
    #1 val = hostRdData;
  endtask

  task automatic checkAllRegs(input string req);
    for (int r = 0; r < 8; r++) begin
      logic [31:0] v;
      readReg(3'(r), v);
      check(req, v, mdl[r]);
    end
  endtask

  task automatic sendFrame(input logic [47:0] mac, input bit gaps, input string req);
    logic exp;
    logic [7:0] b;
    b = binRef(mac);
    exp = mdl[b[7:5]][31 - b[4:0]] & mac[0];
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rxValid = 1'b1; rxLast = (k == 5); rxByte = mac[8*k +: 8];
      if (gaps && k < 5) begin
        @(negedge clk);
        rxValid = 1'b0; rxLast = 1'b1; rxByte = 8'hC3;
        check({req, " no decision mid-frame"}, {31'b0, acceptValid}, 32'd0);
      end
    end
    @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0; rxByte = '0;
    check({req, " acceptValid"}, {31'b0, acceptValid}, 32'd1);
    check({req, " accept"}, {31'b0, accept}, {31'b0, exp});
    @(negedge clk);
    check({req, " R4 pulse ends"}, {31'b0, acceptValid}, 32'd0);
  endtask

  task automatic issueCmd(input logic [47:0] mac, input bit doSet);
    logic [7:0] b;
    b = binRef(mac);
    @(negedge clk);
    cmdMac = mac; cmdSet = doSet; cmdClr = !doSet;
    @(negedge clk);
    cmdSet = 1'b0; cmdClr = 1'b0;
    if (doSet) mdl[b[7:5]] = mdl[b[7:5]] | maskOf(b);
    else       mdl[b[7:5]] = mdl[b[7:5]] & ~maskOf(b);
  endtask

  task automatic t_reset();
    checkAllRegs("R1 table zero");
    check("R1 acceptValid", {31'b0, acceptValid}, 32'd0);
    check("R1 accept", {31'b0, accept}, 32'd0);
  endtask

  task automatic t_hostWrite();
    @(negedge clk);
    hostWrEn = 1'b1; hostWrIdx = 3'd3; hostWrData = 32'hA5A50F0F;
    @(negedge clk);
    hostWrEn = 1'b0;
    mdl[3] = 32'hA5A50F0F;
    checkAllRegs("R6 write whole register");
    @(negedge clk);
    hostWrEn = 1'b1; hostWrIdx = 3'd3; hostWrData = 32'h0;
    @(negedge clk);
    hostWrEn = 1'b0;
    mdl[3] = 32'h0;
    checkAllRegs("R6 write back zero");
  endtask

  task automatic t_setClear(input logic [47:0] mac);
    issueCmd(mac, 1'b1);
    checkAllRegs("R7 R3 single bin set");
    issueCmd(mac, 1'b0);
    checkAllRegs("R8 single bin cleared");
  endtask

  task automatic t_lookups(input logic [47:0] grpA, grpB, indiv);
    sendFrame(grpA, 1'b0, "R1 nothing passes when empty");
    issueCmd(grpA, 1'b1);
    sendFrame(grpA, 1'b0, "R2 member group address");
    sendFrame(grpB, 1'b0, "R5 other group address");
    issueCmd(indiv, 1'b1);
    sendFrame(indiv, 1'b0, "R5 individual address with bin set");
    sendFrame(grpA, 1'b1, "R11 gaps inside address");
    sendFrame(grpA, 1'b0, "R11 back to back frame");
  endtask

  task automatic t_sameCycle(input logic [47:0] mac);
    logic [7:0] b;
    b = binRef(mac);
    if (mdl[b[7:5]][31 - b[4:0]]) issueCmd(mac, 1'b0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      rxValid = 1'b1; rxLast = (k == 5); rxByte = mac[8*k +: 8];
      if (k == 5) begin cmdMac = mac; cmdSet = 1'b1; end
    end
    @(negedge clk);
    rxValid = 1'b0; rxLast = 1'b0; cmdSet = 1'b0;
    mdl[b[7:5]] = mdl[b[7:5]] | maskOf(b);
    check("R10 decision uses old table", {31'b0, accept}, 32'd0);
    sendFrame(mac, 1'b0, "R10 next frame sees new bin");
  endtask

  task automatic t_priority(input logic [47:0] mac);
    logic [7:0] b;
    b = binRef(mac);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrIdx = b[7:5]; hostWrData = 32'h0;
    cmdMac = mac; cmdSet = 1'b1; cmdClr = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0; cmdSet = 1'b0; cmdClr = 1'b0;
    mdl[b[7:5]] = maskOf(b);
    checkAllRegs("R9 write then set wins");
  endtask

  logic done = 1'b0;

  initial begin
    logic [47:0] gA, gB, ind, gC;
    gA  = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01);
    gB  = mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'hFB);
    ind = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    gC  = mk(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    for (int r = 0; r < 8; r++) mdl[r] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_hostWrite();
    t_setClear(gB);
    t_setClear(gC);
    t_lookups(gA, gB, ind);
    t_sameCycle(gC);
    t_priority(gB);
    sendFrame(gB, 1'b0, "R9 bin from combined action");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule